// File: doc/BRIEF.md
# Leading / Trailing Zero Counter

A purely combinational unit that reports how many zero bits sit in front of the first set bit of a 64-bit operand. The scan can start from the most significant end (leading zeros) or from the least significant end (trailing zeros). It can cover all 64 bits or only the low 32 bits. A single datapath serves all four combinations.

The operand is first shaped so that every operation becomes a leading-zero scan of a 64-bit word. For a trailing scan the bits are mirrored. In 32-bit mode the low half is moved to the top and the bottom half is padded with zeros.

The shaped word goes into a tree built from one 4-bit priority encoder. That encoder runs on every nibble, then again on each group of four nibble-valid flags, and finally on the four group flags. Each upper level steers a 4:1 selector. All of this logic is always evaluated. The all-zero test only chooses whether the count comes from the tree or from the mode-dependent width.

Top module: `zcount_unit`

## Requirements
- R1: With trail_i=0 and half_i=0, cnt_o equals the number of zero bits above the highest set bit of opnd_i[63:0].
- R2: With trail_i=1 and half_i=0, cnt_o equals the number of zero bits below the lowest set bit of opnd_i[63:0].
- R3: With trail_i=0 and half_i=1, cnt_o equals the number of zero bits above the highest set bit of opnd_i[31:0], counted from bit 31.
- R4: With trail_i=1 and half_i=1, cnt_o equals the number of zero bits below the lowest set bit of opnd_i[31:0].
- R5: With half_i=0 and opnd_i equal to zero, cnt_o is 64 in both scan directions.
- R6: With half_i=1 and opnd_i[31:0] equal to zero, cnt_o is 32 in both scan directions, whatever opnd_i[63:32] holds.
- R7: With half_i=1, opnd_i[63:32] has no effect on cnt_o.
- R8: The unit holds no state. cnt_o reflects the present inputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 64 | Operand to scan |
| trail_i | input | 1 | 1 = count trailing zeros, 0 = count leading zeros |
| half_i | input | 1 | 1 = scan only bits 31:0, 0 = scan all 64 bits |
| cnt_o | output | 7 | Zero count, 0 to 64 |

## Verification
The immediate assertions assume that the inputs hold known 0/1 values whenever the output settles. The bench drives every input from time zero and changes them only at one clock edge, then samples at the opposite edge. The check that the selected bit is set depends on the all-zero guard being correct for the active mode. The stimulus therefore covers zero operands, single-bit operands at every position, and random operands with a dense or sparse relevant half in all four modes. In 32-bit mode it also pairs each low half with different upper halves.

// File: rtl/zc_pkg.sv
package zc_pkg;
  typedef struct packed {
    logic       any;
    logic [1:0] idx;   // zeros in front of first set bit, MSB first
  } enc4_t;

  function automatic enc4_t enc4(input logic [3:0] v);
    enc4_t r;
    r.any = |v;
    if (v[3])      r.idx = 2'd0;
    else if (v[2]) r.idx = 2'd1;
    else if (v[1]) r.idx = 2'd2;
    else           r.idx = 2'd3;
    return r;
  endfunction
endpackage

// File: rtl/zc_prep.sv
module zc_prep #(
  parameter int W = 64
) (
  input  logic [W-1:0] opnd_i,
  input  logic         trail_i,
  input  logic         half_i,
  output logic [W-1:0] x_o
);
  localparam int H = W / 2;

  logic [W-1:0] rev_full;
  logic [H-1:0] rev_half;

  always_comb begin
    for (int i = 0; i < W; i++) rev_full[i] = opnd_i[W-1-i];
    for (int i = 0; i < H; i++) rev_half[i] = opnd_i[H-1-i];
  end

  always_comb begin
    unique case ({half_i, trail_i})
      2'b00:   x_o = opnd_i;
      2'b01:   x_o = rev_full;
      2'b10:   x_o = {opnd_i[H-1:0], {H{1'b0}}};
      default: x_o = {rev_half, {H{1'b0}}};
    endcase
  end
endmodule

// File: rtl/zc_merge.sv
module zc_merge
  import zc_pkg::*;
#(
  parameter int CW = 2
) (
  input  logic [3:0]         any_i,
  input  logic [3:0][CW-1:0] cnt_i,   // index 3 is the most significant child
  output logic               any_o,
  output logic [CW+1:0]      cnt_o
);
  enc4_t e;
  logic [1:0] pick;

  assign e     = enc4(any_i);
  assign pick  = 2'd3 - e.idx;
  assign any_o = e.any;
  assign cnt_o = {e.idx, cnt_i[pick]};

  always_comb begin
    // R1
    if (any_o) begin
      pick_live_chk: assert (any_i[pick]);
    end
  end
endmodule

// File: rtl/zc_tree.sv
module zc_tree
  import zc_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0]         x_i,
  output logic                 any_o,
  output logic [$clog2(W)-1:0] cnt_o
);
  localparam int NIB = W / 4;
  localparam int GRP = NIB / 4;   // root merges exactly four groups

  logic [NIB-1:0]       nib_any;
  logic [NIB-1:0][1:0]  nib_cnt;
  logic [GRP-1:0]       grp_any;
  logic [GRP-1:0][3:0]  grp_cnt;

  for (genvar n = 0; n < NIB; n++) begin : g_leaf
    enc4_t leaf;
    assign leaf       = enc4(x_i[4*n +: 4]);
    assign nib_any[n] = leaf.any;
    assign nib_cnt[n] = leaf.idx;
  end

  for (genvar g = 0; g < GRP; g++) begin : g_grp
    zc_merge #(.CW(2)) u_mrg (
      .any_i (nib_any[4*g +: 4]),
      .cnt_i (nib_cnt[4*g +: 4]),
      .any_o (grp_any[g]),
      .cnt_o (grp_cnt[g])
    );
  end

  zc_merge #(.CW(4)) u_root (
    .any_i (grp_any),
    .cnt_i (grp_cnt),
    .any_o (any_o),
    .cnt_o (cnt_o)
  );
endmodule

// File: rtl/zcount_unit.sv
module zcount_unit #(
  parameter int W = 64
) (
  input  logic [W-1:0]           opnd_i,
  input  logic                   trail_i,
  input  logic                   half_i,
  output logic [$clog2(W):0]     cnt_o
);
  localparam int H  = W / 2;
  localparam int CW = $clog2(W) + 1;
  localparam logic [CW-1:0] FULL_C = CW'(W);
  localparam logic [CW-1:0] HALF_C = CW'(H);

  logic [W-1:0]    x;
  logic            any;
  logic [CW-2:0]   tcnt;

  zc_prep #(.W(W)) u_prep (
    .opnd_i  (opnd_i),
    .trail_i (trail_i),
    .half_i  (half_i),
    .x_o     (x)
  );

  zc_tree #(.W(W)) u_tree (
    .x_i   (x),
    .any_o (any),
    .cnt_o (tcnt)
  );

  // tree always evaluated; zero test only picks the source
  assign cnt_o = any ? {1'b0, tcnt} : (half_i ? HALF_C : FULL_C);

  always_comb begin
    // R5
    if (!half_i && opnd_i == '0) begin
      zero_full_chk: assert (cnt_o == FULL_C);
    end
    // R6
    if (half_i && opnd_i[H-1:0] == '0) begin
      zero_half_chk: assert (cnt_o == HALF_C);
    end
    // R1
    if (!half_i && !trail_i && opnd_i != '0) begin
      lead_full_chk: assert (int'(cnt_o) < W && opnd_i[W-1-int'(cnt_o)]);
    end
    // R2
    if (!half_i && trail_i && opnd_i != '0) begin
      trail_full_chk: assert (int'(cnt_o) < W && opnd_i[int'(cnt_o)]);
    end
    // R3
    if (half_i && !trail_i && opnd_i[H-1:0] != '0) begin
      lead_half_chk: assert (int'(cnt_o) < H && opnd_i[H-1-int'(cnt_o)]);
    end
    // R4
    if (half_i && trail_i && opnd_i[H-1:0] != '0) begin
      trail_half_chk: assert (int'(cnt_o) < H && opnd_i[int'(cnt_o)]);
    end
  end
endmodule

// File: tb/zcount_unit_test.sv
module zcount_unit_test;
  localparam int PERIOD = 10;
  localparam int W = 64;

  logic          clk = 1'b0;
  logic [W-1:0]  opnd = '0;
  logic          trail = 1'b0;
  logic          half = 1'b0;
  logic [6:0]    cnt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  zcount_unit uut (
    .opnd_i  (opnd),
    .trail_i (trail),
    .half_i  (half),
    .cnt_o   (cnt)
  );

  function automatic int model(logic [63:0] v, bit tr, bit hf);
    int span = hf ? 32 : 64;
    int n = 0;
    for (int i = 0; i < span; i++) begin
      int pos = tr ? i : span - 1 - i;
      if (v[pos]) return n;
      n++;
    end
    return n;
  endfunction

  function automatic string tag(logic [63:0] v, bit tr, bit hf);
    if (!hf && v == '0) return "R5";
    if (hf && v[31:0] == '0) return "R6";
    case ({hf, tr})
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  // drive at posedge, compare at negedge
  task automatic apply(logic [63:0] v, bit tr, bit hf);
    int exp;
    @(posedge clk);
    opnd = v; trail = tr; half = hf;
    @(negedge clk);
    exp = model(v, tr, hf);
    checks++;
    if (int'(cnt) != exp) begin
      errors++;
      $display("FAIL %s opnd=%h trail=%0d half=%0d got %0d exp %0d",
               tag(v, tr, hf), v, tr, hf, cnt, exp);
    end
  endtask

  task automatic all_modes(logic [63:0] v);
    for (int m = 0; m < 4; m++) apply(v, m[0], m[1]);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [63:0] r;
    int c0, c1;
    // R8: output settles with no edge involved
    #1;
    checks++;
    if (cnt != 7'd64) begin
      errors++;
      $display("FAIL R8 idle output got %0d exp 64", cnt);
    end
    opnd = 64'h0000_0100_0000_0000; #1;
    checks++;
    if (cnt != 7'd23) begin
      errors++;
      $display("FAIL R8 combinational update got %0d exp 23", cnt);
    end

    // R5 R6 zero and near-zero corners
    all_modes(64'h0);
    all_modes(64'hFFFF_FFFF_0000_0000);
    all_modes(64'hFFFF_FFFF_FFFF_FFFF);
    all_modes(64'h8000_0000_0000_0001);
    all_modes(64'h0000_0000_8000_0000);

    // R1 R2 R3 R4 single bit at every position
    for (int p = 0; p < 64; p++) all_modes(64'h1 << p);
    // walking run of ones from each end
    for (int p = 0; p < 64; p++) begin
      all_modes(~64'h0 << p);
      all_modes(~64'h0 >> p);
    end

    // dense and sparse random operands
    for (int k = 0; k < 600; k++) begin
      r = {$urandom, $urandom};
      if (k % 3 == 1) r = r & {$urandom, $urandom} & {$urandom, $urandom};
      if (k % 3 == 2) r = r & (64'h1 << ($urandom % 64)) | (64'h1 << ($urandom % 64));
      all_modes(r);
    end

    // R7 upper half has no effect in 32-bit mode
    for (int k = 0; k < 200; k++) begin
      r = {32'h0, ($urandom >> ($urandom % 32))};
      for (int tr = 0; tr < 2; tr++) begin
        apply(r, tr[0], 1'b1);
        c0 = int'(cnt);
        apply({$urandom, r[31:0]}, tr[0], 1'b1);
        c1 = int'(cnt);
        checks++;
        if (c0 != c1) begin
          errors++;
          $display("FAIL R7 upper bits changed count got %0d exp %0d", c1, c0);
        end
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule